// File: doc/BRIEF.md
# Two-Way Message Mailbox with Handshake Interrupts

This block passes short control messages between a host-side bus agent and an embedded processor that share one clock. There are two 32-bit mailboxes, one for each direction. Each side sees a small register window of four word registers. Writing the message register posts a message into that side's outbound mailbox. Reading the message register takes the message from the inbound mailbox.

Posting a message raises a "new message" cause at the receiver. When the receiver reads the message, a "message consumed" cause is raised back at the sender. Each message therefore gets a two-way handshake. Causes latch into pending bits, which software clears by writing one to them. Each side has an enable mask that decides which pending causes drive its level interrupt line. The status register shows both full flags and a sticky overrun bit, which records that the sender wrote over a message nobody had read.

Top module: `mbox_pair`

## Requirements
- R1: After reset, both mailboxes are empty and hold zero. All status, pending and enable bits are zero, and both interrupt lines are low.
- R2: A write to address 0 (message) posts the data to that side's outbound mailbox. From the next cycle, the receiver's status bit 0 (inbound full) is set, the sender's status bit 1 (outbound full) is set, and the receiver's pending bit 0 (new message) is set.
- R3: The interrupt line of a side is high exactly while a pending bit is set whose enable bit is also set at address 3. Pending bits are set whether or not they are enabled.
- R4: With re high at address 0, rdata returns the inbound mailbox in the same cycle. If the mailbox was full, from the next cycle it is empty and the sender's pending bit 1 (message consumed) is set.
- R5: Writing one to a bit of address 2 (pending) clears that pending bit. Writing zero to a bit leaves it unchanged.
- R6: The processor-to-host direction behaves in the same way as the host-to-processor direction. The two directions are independent.
- R7: A write to a full outbound mailbox replaces the data and sets the sender's sticky overrun bit (status bit 2). Writing one to status bit 2 clears it.
- R8: If the sender writes and the receiver reads the same mailbox in one cycle, the read returns the old message. The full flag ends set with the new data, and no overrun is recorded.
- R9: A read of an empty mailbox does not set the sender's consumed pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host register write strobe |
| h_re | input | 1 | Host register read strobe |
| h_addr | input | 2 | Host register select: 0 message, 1 status, 2 pending, 3 enable |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from the address |
| h_irq | output | 1 | Host interrupt, level |
| p_we | input | 1 | Processor register write strobe |
| p_re | input | 1 | Processor register read strobe |
| p_addr | input | 2 | Processor register select, same map as the host |
| p_wdata | input | 32 | Processor write data |
| p_rdata | output | 32 | Processor read data, combinational from the address |
| p_irq | output | 1 | Processor interrupt, level |

## Verification
The bench targets a write and a read of the same mailbox in the same cycle. A design that let the write win would return the new message to the reader, and one that let the read win would end with the mailbox empty and the new message lost. It also writes twice without an intervening read, to catch a design that keeps the first data or never sets the overrun bit. It reads an empty mailbox, where a careless design would still send a false "consumed" interrupt to the sender. Finally, it raises causes while they are masked and then enables them, to catch a design that gates the pending bit itself instead of only the interrupt line.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_MSG  = 2'd0,
        REG_STAT = 2'd1,
        REG_PEND = 2'd2,
        REG_IEN  = 2'd3
    } reg_sel_e;

    localparam int unsigned STAT_IN_FULL  = 0;
    localparam int unsigned STAT_OUT_FULL = 1;
    localparam int unsigned STAT_OUT_OVR  = 2;

    localparam int unsigned PEND_NEW  = 0;
    localparam int unsigned PEND_CONS = 1;
    localparam int unsigned CAUSE_W   = 2;

    localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/mbox_chan.sv
module mbox_chan #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              clr_ovr,
    input  logic              clr_new,
    input  logic              clr_cons,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ovr,
    output logic              new_pend,
    output logic              cons_pend
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              nw;
        logic              cons;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     take;

    always_comb begin
        st_d = st_q;
        take = pop && st_q.full;

        if (push) begin
            st_d.data = push_data;
        end

        if (push) begin
            st_d.full = 1'b1;
        end else if (take) begin
            st_d.full = 1'b0;
        end

        if (push && st_q.full && !take) begin
            st_d.ovr = 1'b1;
        end else if (clr_ovr) begin
            st_d.ovr = 1'b0;
        end

        if (push) begin
            st_d.nw = 1'b1;
        end else if (clr_new) begin
            st_d.nw = 1'b0;
        end

        if (take) begin
            st_d.cons = 1'b1;
        end else if (clr_cons) begin
            st_d.cons = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data      = st_q.data;
    assign full      = st_q.full;
    assign ovr       = st_q.ovr;
    assign new_pend  = st_q.nw;
    assign cons_pend = st_q.cons;
endmodule

// File: rtl/mbox_side.sv
module mbox_side
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic                  re,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  irq,
    input  logic [DATA_W-1:0]     in_data,
    input  logic                  in_full,
    input  logic                  in_new,
    input  logic                  out_full,
    input  logic                  out_ovr,
    input  logic                  out_cons,
    output logic                  push,
    output logic                  pop,
    output logic                  clr_ovr,
    output logic                  clr_new,
    output logic                  clr_cons
);
    typedef struct packed {
        logic [CAUSE_W-1:0] ien;
    } side_st_t;

    side_st_t           st_d, st_q;
    reg_sel_e           sel;
    logic [CAUSE_W-1:0] pend;
    logic               irq_d, irq_q;

    always_comb begin
        sel                 = reg_sel_e'(addr);
        pend                = '0;
        pend[PEND_NEW]      = in_new;
        pend[PEND_CONS]     = out_cons;

        push     = we && (sel == REG_MSG);
        pop      = re && (sel == REG_MSG);
        clr_ovr  = we && (sel == REG_STAT) && wdata[STAT_OUT_OVR];
        clr_new  = we && (sel == REG_PEND) && wdata[PEND_NEW];
        clr_cons = we && (sel == REG_PEND) && wdata[PEND_CONS];

        st_d = st_q;
        if (we && (sel == REG_IEN)) begin
            st_d.ien = wdata[CAUSE_W-1:0];
        end

        rdata = '0;
        unique case (sel)
            REG_MSG:  rdata = in_data;
            REG_STAT: begin
                rdata[STAT_IN_FULL]  = in_full;
                rdata[STAT_OUT_FULL] = out_full;
                rdata[STAT_OUT_OVR]  = out_ovr;
            end
            REG_PEND: rdata[CAUSE_W-1:0] = pend;
            REG_IEN:  rdata[CAUSE_W-1:0] = st_q.ien;
            default:  rdata = '0;
        endcase

        irq_d = |(pend & st_q.ien);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // irq is a pure function of registered state; keep it combinational
    always_comb irq_q = irq_d;
    assign irq = irq_q;
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  h_we,
    input  logic                  h_re,
    input  logic [REG_ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0]     h_wdata,
    output logic [DATA_W-1:0]     h_rdata,
    output logic                  h_irq,
    input  logic                  p_we,
    input  logic                  p_re,
    input  logic [REG_ADDR_W-1:0] p_addr,
    input  logic [DATA_W-1:0]     p_wdata,
    output logic [DATA_W-1:0]     p_rdata,
    output logic                  p_irq
);
    // index 0: host side, owns channel 0 (host to processor)
    // index 1: processor side, owns channel 1 (processor to host)
    logic [NUM_SIDES-1:0]                 s_we, s_re, s_irq;
    logic [NUM_SIDES-1:0][REG_ADDR_W-1:0] s_addr;
    logic [NUM_SIDES-1:0][DATA_W-1:0]     s_wdata, s_rdata;
    logic [NUM_SIDES-1:0]                 s_push, s_pop, s_clr_ovr, s_clr_new, s_clr_cons;

    logic [NUM_SIDES-1:0][DATA_W-1:0]     ch_data;
    logic [NUM_SIDES-1:0]                 ch_full, ch_ovr, ch_new, ch_cons;

    assign s_we[0]    = h_we;
    assign s_re[0]    = h_re;
    assign s_addr[0]  = h_addr;
    assign s_wdata[0] = h_wdata;
    assign s_we[1]    = p_we;
    assign s_re[1]    = p_re;
    assign s_addr[1]  = p_addr;
    assign s_wdata[1] = p_wdata;

    assign h_rdata = s_rdata[0];
    assign h_irq   = s_irq[0];
    assign p_rdata = s_rdata[1];
    assign p_irq   = s_irq[1];

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_dir
        localparam int unsigned OTH = NUM_SIDES - 1 - s;

        mbox_chan #(.DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (s_push[s]),
            .push_data (s_wdata[s]),
            .pop       (s_pop[OTH]),
            .clr_ovr   (s_clr_ovr[s]),
            .clr_new   (s_clr_new[OTH]),
            .clr_cons  (s_clr_cons[s]),
            .data      (ch_data[s]),
            .full      (ch_full[s]),
            .ovr       (ch_ovr[s]),
            .new_pend  (ch_new[s]),
            .cons_pend (ch_cons[s])
        );

        mbox_side #(.DATA_W(DATA_W)) u_side (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (s_we[s]),
            .re       (s_re[s]),
            .addr     (s_addr[s]),
            .wdata    (s_wdata[s]),
            .rdata    (s_rdata[s]),
            .irq      (s_irq[s]),
            .in_data  (ch_data[OTH]),
            .in_full  (ch_full[OTH]),
            .in_new   (ch_new[OTH]),
            .out_full (ch_full[s]),
            .out_ovr  (ch_ovr[s]),
            .out_cons (ch_cons[s]),
            .push     (s_push[s]),
            .pop      (s_pop[s]),
            .clr_ovr  (s_clr_ovr[s]),
            .clr_new  (s_clr_new[s]),
            .clr_cons (s_clr_cons[s])
        );
    end
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk
    import mbox_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  h_we,
    input logic                  h_re,
    input logic [REG_ADDR_W-1:0] h_addr,
    input logic [2:0]            h_wlow,
    input logic                  p_we,
    input logic                  p_re,
    input logic [REG_ADDR_W-1:0] p_addr,
    input logic                  p_irq,
    input logic [1:0]            ch_full,
    input logic [1:0]            ch_ovr,
    input logic [1:0]            ch_new,
    input logic [1:0]            ch_cons
);
    logic h_post, p_post, h_take, p_take;
    assign h_post = h_we && (h_addr == 2'd0);
    assign p_post = p_we && (p_addr == 2'd0);
    assign h_take = h_re && (h_addr == 2'd0);
    assign p_take = p_re && (p_addr == 2'd0);

    assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        h_post |=> (ch_full[0] && ch_new[0]));

    assert_irq_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_irq) |-> (ch_new[0] || ch_cons[1]));

    assert_read_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p_take && ch_full[0] && !h_post) |=> (!ch_full[0] && ch_cons[0]));

    assert_p2h_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        p_post |=> (ch_full[1] && ch_new[1]));

    assert_host_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_take && ch_full[1] && !p_post) |=> (!ch_full[1] && ch_cons[1]));

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ovr[0] && !(h_we && (h_addr == 2'd1) && h_wlow[2])) |=> ch_ovr[0]);

    assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_post && p_take && ch_full[0]) |=> (ch_full[0] && ($past(ch_ovr[0]) == ch_ovr[0] || !ch_ovr[0])));

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (p_take && !ch_full[0] && !h_post && !ch_cons[0]) |=> !ch_cons[0]);
endmodule

bind mbox_pair mbox_pair_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_we    (h_we),
    .h_re    (h_re),
    .h_addr  (h_addr),
    .h_wlow  (h_wdata[2:0]),
    .p_we    (p_we),
    .p_re    (p_re),
    .p_addr  (p_addr),
    .p_irq   (p_irq),
    .ch_full (ch_full),
    .ch_ovr  (ch_ovr),
    .ch_new  (ch_new),
    .ch_cons (ch_cons)
);

// File: tb/test_mbox_pair.sv
`timescale 1ns/1ps
module test_mbox_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_we = 0, h_re = 0, p_we = 0, p_re = 0;
    logic [1:0]  h_addr = 0, p_addr = 0;
    logic [31:0] h_wdata = 0, p_wdata = 0;
    logic [31:0] h_rdata, p_rdata;
    logic        h_irq, p_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    mbox_pair i_mbox_pair (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_re(h_re), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq),
        .p_we(p_we), .p_re(p_re), .p_addr(p_addr), .p_wdata(p_wdata),
        .p_rdata(p_rdata), .p_irq(p_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // side 0 = host, 1 = processor
    task automatic wr(input bit side, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        if (!side) begin h_we = 1; h_addr = a; h_wdata = d; end
        else       begin p_we = 1; p_addr = a; p_wdata = d; end
        @(negedge clk);
        h_we = 0; p_we = 0;
    endtask

    task automatic rd(input bit side, output logic [31:0] v);
        @(negedge clk);
        if (!side) begin h_re = 1; h_addr = 2'd0; #1 v = h_rdata; end
        else       begin p_re = 1; p_addr = 2'd0; #1 v = p_rdata; end
        @(negedge clk);
        h_re = 0; p_re = 0;
    endtask

    task automatic peek(input bit side, input logic [1:0] a, output logic [31:0] v);
        if (!side) begin h_addr = a; #1 v = h_rdata; end
        else       begin p_addr = a; #1 v = p_rdata; end
    endtask

    task automatic clear_all();
        wr(0, 2'd2, 32'h3);
        wr(1, 2'd2, 32'h3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 4; a++) begin
                peek(s[0], a[1:0], v);
                chk("R1 reset register", v, 32'h0);
            end
        end
        chk("R1 reset h_irq", {31'b0, h_irq}, 32'h0);
        chk("R1 reset p_irq", {31'b0, p_irq}, 32'h0);
    endtask

    task automatic t_h2p();
        logic [31:0] v;
        wr(1, 2'd3, 32'h3);
        wr(0, 2'd0, 32'hA5A5_0001);
        peek(1, 2'd1, v); chk("R2 p inbound full", v, 32'h1);
        peek(0, 2'd1, v); chk("R2 h outbound full", v, 32'h2);
        peek(1, 2'd2, v); chk("R2 p new pending", v, 32'h1);
        chk("R3 p_irq enabled", {31'b0, p_irq}, 32'h1);
        rd(1, v); chk("R4 p read data", v, 32'hA5A5_0001);
        peek(0, 2'd1, v); chk("R4 h outbound empty", v, 32'h0);
        peek(0, 2'd2, v); chk("R4 h consumed pending", v, 32'h2);
        chk("R3 h_irq masked", {31'b0, h_irq}, 32'h0);
        wr(0, 2'd3, 32'h2);
        chk("R3 h_irq after enable", {31'b0, h_irq}, 32'h1);
        wr(0, 2'd2, 32'h1);
        peek(0, 2'd2, v); chk("R5 zero bit keeps pending", v, 32'h2);
        wr(0, 2'd2, 32'h2);
        peek(0, 2'd2, v); chk("R5 h pending cleared", v, 32'h0);
        chk("R5 h_irq drops", {31'b0, h_irq}, 32'h0);
        wr(1, 2'd2, 32'h1);
        chk("R5 p_irq drops", {31'b0, p_irq}, 32'h0);
    endtask

    task automatic t_p2h();
        logic [31:0] v;
        wr(0, 2'd3, 32'h1);
        wr(1, 2'd0, 32'h1234_5678);
        peek(0, 2'd1, v); chk("R6 h inbound full", v, 32'h1);
        chk("R6 h_irq new msg", {31'b0, h_irq}, 32'h1);
        peek(1, 2'd1, v); chk("R6 p outbound full", v, 32'h2);
        rd(0, v); chk("R6 h read data", v, 32'h1234_5678);
        peek(1, 2'd2, v); chk("R6 p consumed pending", v, 32'h2);
        chk("R6 p_irq consumed", {31'b0, p_irq}, 32'h1);
        clear_all();
        chk("R6 irqs cleared", {30'b0, h_irq, p_irq}, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        wr(0, 2'd0, 32'h11);
        wr(0, 2'd0, 32'h22);
        peek(0, 2'd1, v); chk("R7 full and overrun", v, 32'h6);
        rd(1, v); chk("R7 data replaced", v, 32'h22);
        peek(0, 2'd1, v); chk("R7 overrun sticky", v, 32'h4);
        wr(0, 2'd1, 32'h4);
        peek(0, 2'd1, v); chk("R7 overrun cleared", v, 32'h0);
        clear_all();
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        wr(0, 2'd0, 32'h33);
        @(negedge clk);
        h_we = 1; h_addr = 2'd0; h_wdata = 32'h44;
        p_re = 1; p_addr = 2'd0;
        #1 v = p_rdata;
        chk("R8 read returns old", v, 32'h33);
        @(negedge clk);
        h_we = 0; p_re = 0;
        peek(0, 2'd1, v); chk("R8 full kept, no overrun", v, 32'h2);
        rd(1, v); chk("R8 new data kept", v, 32'h44);
        clear_all();
    endtask

    task automatic t_empty_read();
        logic [31:0] v;
        rd(1, v);
        peek(0, 2'd2, v); chk("R9 no consumed pending", v, 32'h0);
        chk("R9 h_irq stays low", {31'b0, h_irq}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_h2p();
        t_p2h();
        t_overrun();
        t_same_cycle();
        t_empty_read();
        finish_run();
    end
endmodule